// File: doc/BRIEF.md
# Carry-Rotating Left Shifter with Status Flags

This unit carries out a single-step left rotation through the carry flag. The operand may be a full 16-bit word or its low byte. The caller presents an operand, the present carry and three processor mode bits, and sets a size control input that chooses byte or word width. It raises an input strobe for one operation. One clock later the unit presents the rotated value together with fresh negative, zero, carry and overflow flags. The mode bits come back out exactly as they went in.

The rotation is the same as adding the operand to itself with the incoming carry as carry-in. The bit shifted out at the top of the selected width becomes the new carry. The overflow flag marks operands whose two top bits differ, which means the doubling changed the sign. When no operation is issued, all outputs hold their values. A synchronous reset clears every output.

Top module: `rotc_unit`

## Requirements
- R1: The registered result equals (2 × operand + carry) truncated to the selected width. In byte mode (`byteMode` = 1) bits 15..8 of `result` are 0 and operand bits 15..8 have no effect.
- R2: The new carry `flagC` equals operand bit 15 in word mode and operand bit 7 in byte mode.
- R3: `flagN` equals the top bit of the result at the selected width: bit 15 for word, bit 7 for byte.
- R4: `flagZ` is 1 exactly when the result at the selected width is all zeros.
- R5: In word mode `flagV` is 1 exactly when 0x4000 ≤ operand < 0xC000.
- R6: In byte mode `flagV` is 1 exactly when 0x40 ≤ operand[7:0] < 0xC0.
- R7: `modeOut` equals the `modeIn` value presented with the strobe, bit for bit. Bit 0 is oscillator-off, bit 1 is CPU-off and bit 2 is global interrupt enable.
- R8: `outValid` is high in exactly the cycle after a cycle with `inValid` high. Without a strobe, `result`, the flags and `modeOut` keep their values whatever the other inputs do.
- R9: While `rstN` is low at a clock edge, `result`, all flags, `modeOut` and `outValid` are cleared to 0 at that edge, even if `inValid` is high.
- R10: The overflow flag equals the XOR of the top two operand bits at the selected width (bits 15 and 14 for word, bits 7 and 6 for byte).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| byteMode | input | 1 | 1 = byte width, 0 = word width |
| operand | input | 16 | Destination operand |
| carryIn | input | 1 | Current carry flag |
| modeIn | input | 3 | Mode bits {GIE, CPU-off, osc-off} |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| result | output | 16 | Rotated value |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Overflow flag |
| modeOut | output | 3 | Mode bits passed through |

## Verification
The assertions assume that `byteMode`, `operand`, `carryIn` and `modeIn` are settled around the clock edge at which `inValid` is sampled. The bench meets this by driving every input on the falling edge. The flag checks also assume that reset was applied at the first edge, since flags are only compared after a load. Every byte operand is swept with both carry values, and random garbage is placed in the upper operand byte each time. Word operands are swept on a stride, with the range edges 0x3FFF, 0x4000, 0xBFFF and 0xC000 added explicitly.

// File: rtl/rotc_pkg.sv
package rotc_pkg;
  typedef struct packed {
    logic load;
    logic clear;
  } rotcStb_t;
endpackage

// File: rtl/rotc_ctrl.sv
module rotc_ctrl
  import rotc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output rotcStb_t stb,
  output logic     outValid
);
  always_comb begin
    stb.clear = !rstN;
    stb.load  = rstN && inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/rotc_dp.sv
module rotc_dp
  import rotc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rotcStb_t          stb,
  input  logic              byteMode,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic [2:0]        modeIn,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagV,
  output logic [2:0]        modeOut
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] WORD_LO = DATA_W'(1) << (DATA_W - 2);
  localparam logic [DATA_W-1:0] WORD_HI = DATA_W'(3) << (DATA_W - 2);
  localparam logic [HALF_W-1:0] BYTE_LO = HALF_W'(1) << (HALF_W - 2);
  localparam logic [HALF_W-1:0] BYTE_HI = HALF_W'(3) << (HALF_W - 2);

  logic [HALF_W-1:0] lowByte;
  logic [DATA_W-1:0] wideRes, narrowRes, nextRes;
  logic              nextN, nextZ, nextC, nextV;
  logic              wordV, byteV;
  logic              sizeReg;

  always_comb begin
    lowByte   = operand[HALF_W-1:0];
    wideRes   = {operand[DATA_W-2:0], carryIn};
    narrowRes = {{HALF_W{1'b0}}, lowByte[HALF_W-2:0], carryIn};
    wordV     = (operand >= WORD_LO) && (operand < WORD_HI);
    byteV     = (lowByte >= BYTE_LO) && (lowByte < BYTE_HI);
    if (byteMode) begin
      nextRes = narrowRes;
      nextC   = lowByte[HALF_W-1];
      nextN   = narrowRes[HALF_W-1];
      nextZ   = (narrowRes[HALF_W-1:0] == '0);
      nextV   = byteV;
    end else begin
      nextRes = wideRes;
      nextC   = operand[DATA_W-1];
      nextN   = wideRes[DATA_W-1];
      nextZ   = (wideRes == '0);
      nextV   = wordV;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.clear) begin
      result  <= '0;
      flagN   <= 1'b0;
      flagZ   <= 1'b0;
      flagC   <= 1'b0;
      flagV   <= 1'b0;
      modeOut <= '0;
      sizeReg <= 1'b0;
    end else if (stb.load) begin
      result  <= nextRes;
      flagN   <= nextN;
      flagZ   <= nextZ;
      flagC   <= nextC;
      flagV   <= nextV;
      modeOut <= modeIn;
      sizeReg <= byteMode;
    end
  end

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    sizeReg |-> (result[DATA_W-1:HALF_W] == '0));
  assert_carry_src_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> flagC == ($past(byteMode) ? $past(operand[HALF_W-1]) : $past(operand[DATA_W-1])));
  assert_sign_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.load) |-> flagN == (sizeReg ? result[HALF_W-1] : result[DATA_W-1]));
  assert_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.load) |-> flagZ == (sizeReg ? (result[HALF_W-1:0] == '0) : (result == '0)));
  assert_mode_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> modeOut == $past(modeIn));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(result) && $stable(flagV) && $stable(flagC) && $stable(modeOut));
  assert_v_xor_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> flagV == ($past(byteMode)
      ? ($past(operand[HALF_W-1]) ^ $past(operand[HALF_W-2]))
      : ($past(operand[DATA_W-1]) ^ $past(operand[DATA_W-2]))));
endmodule

// File: rtl/rotc_unit.sv
module rotc_unit
  import rotc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              byteMode,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic [2:0]        modeIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagV,
  output logic [2:0]        modeOut
);
  rotcStb_t stb;

  rotc_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  rotc_dp #(.DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .byteMode (byteMode),
    .operand  (operand),
    .carryIn  (carryIn),
    .modeIn   (modeIn),
    .result   (result),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagC    (flagC),
    .flagV    (flagV),
    .modeOut  (modeOut)
  );
endmodule

// File: tb/tb_rotc_unit.sv
module tb_rotc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCH_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        byteMode = 1'b0;
  logic [15:0] operand = '0;
  logic        carryIn = 1'b0;
  logic [2:0]  modeIn = '0;
  logic        outValid, flagN, flagZ, flagC, flagV;
  logic [15:0] result;
  logic [2:0]  modeOut;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotc_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .byteMode(byteMode),
    .operand(operand), .carryIn(carryIn), .modeIn(modeIn),
    .outValid(outValid), .result(result), .flagN(flagN), .flagZ(flagZ),
    .flagC(flagC), .flagV(flagV), .modeOut(modeOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // Drive at a falling edge, let one rising edge register, check at the next falling edge.
  task automatic runOp(input logic bm, input int op, input int c, input int md);
    int w, v, res, expC, expN, expZ, expV, xorV;
    byteMode = bm; operand = 16'(op); carryIn = c[0]; modeIn = 3'(md); inValid = 1'b1;
    @(negedge clk);
    if (bm) begin
      w = op % 256;
      res = (w * 2 + c) % 256;
      expC = w / 128;
      expN = res / 128;
      expV = (w >= 64 && w < 192) ? 1 : 0;
      xorV = ((w / 128) + (w / 64)) % 2;
      chk("R6 byte overflow", int'(flagV), expV);
      chk("R10 range equals top-bit xor", expV, xorV);
      chk("R10 flag equals top-bit xor", int'(flagV), xorV);
    end else begin
      w = op % 65536;
      res = (w * 2 + c) % 65536;
      expC = w / 32768;
      expN = res / 32768;
      expV = (w >= 16384 && w < 49152) ? 1 : 0;
      chk("R5 word overflow", int'(flagV), expV);
    end
    expZ = (res == 0) ? 1 : 0;
    chk("R1 result", int'(result), res);
    chk("R2 carry", int'(flagC), expC);
    chk("R3 negative", int'(flagN), expN);
    chk("R4 zero", int'(flagZ), expZ);
    chk("R7 mode bits", int'(modeOut), md % 8);
    chk("R8 valid", int'(outValid), 1);
  endtask

  initial begin
    repeat (WATCH_CYCLES) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int prevRes;
    int bounds[8] = '{0, 16'h3FFF, 16'h4000, 16'h8000, 16'hBFFF, 16'hC000, 16'hFFFF, 16'h7FFF};
    repeat (3) @(negedge clk);
    chk("R9 reset result", int'(result), 0);
    chk("R9 reset flags", int'({flagN, flagZ, flagC, flagV}), 0);
    chk("R9 reset valid", int'(outValid), 0);
    rstN = 1'b1;

    // byte sweep, garbage in the upper byte
    for (int b = 0; b < 256; b++)
      for (int c = 0; c < 2; c++)
        runOp(1'b1, ((b * 37 + c * 11 + 5) % 256) * 256 + b, c, b + c);

    // word boundaries with both carries
    foreach (bounds[i])
      for (int c = 0; c < 2; c++)
        runOp(1'b0, bounds[i], c, i);

    // word stride sweep
    for (int i = 0; i < 65536; i += 41)
      runOp(1'b0, i, (i / 41) % 2, i);

    // hold: no strobe, inputs change
    runOp(1'b0, 16'h1234, 1, 5);
    prevRes = int'(result);
    inValid = 1'b0; operand = 16'hFFFF; byteMode = 1'b1; carryIn = 1'b0; modeIn = 3'd2;
    @(negedge clk);
    chk("R8 no valid without strobe", int'(outValid), 0);
    chk("R8 result held", int'(result), prevRes);
    chk("R8 mode held", int'(modeOut), 5);
    chk("R8 carry held", int'(flagC), 0);

    // mid-run reset with strobe high
    runOp(1'b0, 16'hFFFF, 1, 7);
    rstN = 1'b0; inValid = 1'b1; operand = 16'h4000;
    @(negedge clk);
    chk("R9 reset result", int'(result), 0);
    chk("R9 reset flags", int'({flagN, flagZ, flagC, flagV}), 0);
    chk("R9 reset mode", int'(modeOut), 0);
    chk("R9 reset valid", int'(outValid), 0);
    rstN = 1'b1;
    runOp(1'b1, 16'hAB80, 0, 1);
    inValid = 1'b0;
    @(negedge clk);
    finishRun();
  end
endmodule